// File: doc/BRIEF.md
# Calibration Test Signal Generator

This block produces digital calibration stimulus for a measurement front end. All timing comes from one periodic load strobe that acts as a clock enable on the system clock. A binary divider gives a fast square wave at one quarter of the strobe rate and a slow square wave at one sixty-fourth of it. An 8-bit shift-register noise source gives a pseudo-random bit stream that repeats after exactly 256 strobes, and the block can also offer that stream inverted.

Two select inputs, `sel_invert` and `sel_source`, pick which signal drives the calibrator output. A second selector uses the same select code to drive the trigger output. On the trigger output the two noise codes are replaced by the top bit of the generator register, which is a sync marker that repeats once per period. Both outputs are registered, and they update only on strobe-qualified edges, so a change of the select code never produces a partial cycle on either output.

Top module: `cal_stim_gen`

## Requirements
- R1: With `rst_n` low at a rising clock edge (synchronous, active low), the divider clears to 0, the generator register loads the seed 0x01, and both `cal_out` and `trig_out` become 0.
- R2: On a clock edge where `strobe` is low, the divider, the generator and both outputs keep their values.
- R3: Code {sel_invert,sel_source}=00: after the n-th strobe since reset, `cal_out` equals bit 1 of (n-1). This is a 50% square wave with a period of 4 strobes.
- R4: Code 01: after the n-th strobe, `cal_out` equals bit 5 of (n-1). This is a 50% square wave with a period of 64 strobes.
- R5: Code 10: the `cal_out` sequence repeats every 256 strobes, holds exactly 128 ones in each period, and does not repeat every 255 strobes.
- R6: The noise bit is the newest bit of the generator register. After the first strobe following reset, code 10 gives `cal_out`=1 (bit 0 of the seed).
- R7: Code 11: after every strobe, `cal_out` is the complement of the value that code 10 gives after the same strobe count.
- R8: A select change with no strobe leaves both outputs unchanged. The new code shows up after the next strobe.
- R9: Codes 00 and 01: `trig_out` carries the same square wave as `cal_out`.
- R10: Codes 10 and 11: `trig_out` is the generator's most significant bit, not inverted. After the n-th strobe (n≥8) it equals the code-10 `cal_out` value after strobe n-7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strobe | input | 1 | Load strobe; clock enable for all state |
| sel_invert | input | 1 | Upper select bit (noise family / inversion) |
| sel_source | input | 1 | Lower select bit |
| cal_out | output | 1 | Registered calibrator drive |
| trig_out | output | 1 | Registered trigger signal |

## Verification
On every cycle, the assertions check that all state holds when there is no strobe, that the generator shifts by exactly one place per strobe, that the inverted-noise code drives the complement of the noise bit, and that the noise codes put the generator's top bit on the trigger. Other properties can only be shown by the bench's scenarios over whole runs: the square-wave phases relative to reset, the 256-strobe period and the balance of the noise stream, the seven-strobe lag of the trigger marker, and the deferred effect of a select change.

// File: rtl/cal_stim_pkg.sv
// Shared select-code encoding for the calibration stimulus generator.
// Assumes the select code is formed as {sel_invert, sel_source}.
package cal_stim_pkg;
    typedef enum logic [1:0] {
        SRC_FAST    = 2'b00,
        SRC_SLOW    = 2'b01,
        SRC_NOISE   = 2'b10,
        SRC_NOISE_N = 2'b11
    } src_sel_e;

    localparam int unsigned NUM_SRC = 4;
endpackage

// File: rtl/cal_rate_divider.sv
// Binary divider that counts strobes. It gives two 50% square waves
// taken from fixed counter bits. Assumes FAST_TAP < CNT_W.
module cal_rate_divider #(
    parameter int unsigned CNT_W    = 6,
    parameter int unsigned FAST_TAP = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output logic fast_sq,
    output logic slow_sq
);
    localparam int unsigned SLOW_TAP = CNT_W - 1;

    logic [CNT_W-1:0] cnt;

    // Advance the count once per strobe; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (step)
            cnt <= cnt + 1'b1;
    end

    assign fast_sq = cnt[FAST_TAP];
    assign slow_sq = cnt[SLOW_TAP];

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(cnt));
endmodule

// File: rtl/cal_prbs_gen.sv
// Fibonacci shift-register noise source with de Bruijn extension. The
// all-zero state is visited once, so the period is 2**W. Assumes TAP_MASK
// describes a maximal-length feedback set for width W.
module cal_prbs_gen #(
    parameter int unsigned     W        = 8,
    parameter logic [W-1:0]    TAP_MASK = 8'hB8,
    parameter logic [W-1:0]    SEED     = 8'h01
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output logic noise_bit,
    output logic sync_bit
);
    logic [W-1:0] state;
    logic         lin_fb;
    logic         zero_low;
    logic         fb;

    // Form the feedback: parity of the taps, flipped when the low bits are all zero.
    always_comb begin
        lin_fb   = ^(state & TAP_MASK);
        zero_low = (state[W-2:0] == '0);
        fb       = lin_fb ^ zero_low;
    end

    // Shift towards the MSB once per strobe; load the seed on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= SEED;
        else if (step)
            state <= {state[W-2:0], fb};
    end

    assign noise_bit = state[0];
    assign sync_bit  = state[W-1];

    // R6
    shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> state[W-1:1] == $past(state[W-2:0]));
    // R2
    gen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(state));
endmodule

// File: rtl/cal_pick_reg.sv
// One-of-four selector followed by a strobe-qualified output register.
// Assumes cand is indexed by the select code.
module cal_pick_reg
    import cal_stim_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step,
    input  src_sel_e           code,
    input  logic [NUM_SRC-1:0] cand,
    output logic               q
);
    logic pick;

    // Choose the candidate addressed by the select code.
    always_comb begin
        unique case (code)
            SRC_FAST:    pick = cand[0];
            SRC_SLOW:    pick = cand[1];
            SRC_NOISE:   pick = cand[2];
            SRC_NOISE_N: pick = cand[3];
            default:     pick = 1'b0;
        endcase
    end

    // Reclock the chosen signal on strobe edges only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= 1'b0;
        else if (step)
            q <= pick;
    end

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(q));
endmodule

// File: rtl/cal_stim_gen.sv
// Top of the calibration stimulus generator. It joins the divider, the
// noise source and two registered selectors: the calibrator path and the
// trigger path. Assumes strobe is synchronous to clk.
module cal_stim_gen
    import cal_stim_pkg::*;
#(
    parameter int unsigned FAST_LOG2 = 2,
    parameter int unsigned SLOW_LOG2 = 6,
    parameter int unsigned GEN_W     = 8,
    parameter logic [GEN_W-1:0] GEN_TAPS = 8'hB8,
    parameter logic [GEN_W-1:0] GEN_SEED = 8'h01
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic sel_invert,
    input  logic sel_source,
    output logic cal_out,
    output logic trig_out
);
    localparam int unsigned CNT_W    = SLOW_LOG2;
    localparam int unsigned FAST_TAP = FAST_LOG2 - 1;
    localparam int unsigned NUM_PATH = 2;

    logic     fast_sq, slow_sq, noise_bit, sync_bit;
    src_sel_e code;
    logic [NUM_SRC-1:0] cand [NUM_PATH];
    logic [NUM_PATH-1:0] path_q;

    assign code = src_sel_e'({sel_invert, sel_source});

    cal_rate_divider #(.CNT_W(CNT_W), .FAST_TAP(FAST_TAP)) u_div (
        .clk(clk), .rst_n(rst_n), .step(strobe),
        .fast_sq(fast_sq), .slow_sq(slow_sq)
    );

    cal_prbs_gen #(.W(GEN_W), .TAP_MASK(GEN_TAPS), .SEED(GEN_SEED)) u_gen (
        .clk(clk), .rst_n(rst_n), .step(strobe),
        .noise_bit(noise_bit), .sync_bit(sync_bit)
    );

    // Candidate sets: path 0 drives the calibrator, path 1 drives the trigger.
    always_comb begin
        cand[0] = {~noise_bit, noise_bit, slow_sq, fast_sq};
        cand[1] = {sync_bit,   sync_bit,  slow_sq, fast_sq};
    end

    for (genvar p = 0; p < NUM_PATH; p++) begin : g_path
        cal_pick_reg u_pick (
            .clk(clk), .rst_n(rst_n), .step(strobe),
            .code(code), .cand(cand[p]), .q(path_q[p])
        );
    end

    assign cal_out  = path_q[0];
    assign trig_out = path_q[1];

    // R7
    inv_noise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && sel_invert && sel_source) |=> cal_out == !$past(noise_bit));
    // R10
    trig_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && sel_invert) |=> trig_out == $past(sync_bit));
    // R9
    trig_square_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !sel_invert) |=> trig_out == cal_out);
endmodule

// File: tb/cal_stim_gen_bench.sv
module cal_stim_gen_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strobe = 1'b0;
    logic sel_invert = 1'b0;
    logic sel_source = 1'b0;
    logic cal_out, trig_out;
    int   total = 0;
    int   bad = 0;

    always #4 clk = ~clk;

    cal_stim_gen u_cal_stim_gen (
        .clk(clk), .rst_n(rst_n), .strobe(strobe),
        .sel_invert(sel_invert), .sel_source(sel_source),
        .cal_out(cal_out), .trig_out(trig_out)
    );

    // Vector: {code[1:0], strobes after reset[7:0], exp cal, exp trig}
    localparam int NV = 10;
    localparam logic [11:0] VEC [NV] = '{
        {2'b00, 8'd1,  1'b0, 1'b0},   // R3 R9
        {2'b00, 8'd3,  1'b1, 1'b1},   // R3 R9
        {2'b00, 8'd4,  1'b1, 1'b1},   // R3
        {2'b00, 8'd5,  1'b0, 1'b0},   // R3
        {2'b01, 8'd32, 1'b0, 1'b0},   // R4 R9
        {2'b01, 8'd33, 1'b1, 1'b1},   // R4
        {2'b01, 8'd64, 1'b1, 1'b1},   // R4
        {2'b01, 8'd65, 1'b0, 1'b0},   // R4
        {2'b10, 8'd1,  1'b1, 1'b0},   // R6 R10
        {2'b11, 8'd1,  1'b0, 1'b0}    // R7 R10
    };

    logic nz  [512];
    logic tg  [512];
    logic inz [256];

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        strobe = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic pulse(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            strobe = 1'b1;
            @(negedge clk);
            strobe = 1'b0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int ones;
        int diff255;
        // R1: reset state
        do_reset();
        check("R1 cal", cal_out, 1'b0);
        check("R1 trig", trig_out, 1'b0);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            do_reset();
            {sel_invert, sel_source} = VEC[v][11:10];
            pulse(int'(VEC[v][9:2]));
            check($sformatf("R3/R4/R6/R7 vec%0d cal", v), cal_out, VEC[v][1]);
            check($sformatf("R9/R10 vec%0d trig", v), trig_out, VEC[v][0]);
        end

        // R2: no strobe, everything holds
        do_reset();
        {sel_invert, sel_source} = 2'b00;
        pulse(3);
        repeat (20) @(negedge clk);
        check("R2 hold cal", cal_out, 1'b1);
        pulse(1);
        check("R2 resume cal", cal_out, 1'b1);   // fourth strobe, count 3
        pulse(1);
        check("R2 resume cal next", cal_out, 1'b0);

        // R8: select change waits for a strobe
        do_reset();
        {sel_invert, sel_source} = 2'b00;
        pulse(3);
        {sel_invert, sel_source} = 2'b10;
        repeat (5) @(negedge clk);
        check("R8 cal before strobe", cal_out, 1'b1);
        check("R8 trig before strobe", trig_out, 1'b1);
        pulse(1);
        check("R8 cal after strobe", cal_out, 1'b0);
        check("R8 trig after strobe", trig_out, 1'b0);

        // R5/R10: record the noise and trigger streams
        do_reset();
        {sel_invert, sel_source} = 2'b10;
        for (int i = 0; i < 512; i++) begin
            pulse(1);
            nz[i] = cal_out;
            tg[i] = trig_out;
        end
        ones = 0;
        diff255 = 0;
        for (int i = 0; i < 256; i++) begin
            if (nz[i]) ones++;
            if (nz[i] !== nz[i+255]) diff255++;
            check("R5 period 256", nz[i+256], nz[i]);
        end
        total++;
        if (ones != 128) begin
            bad++;
            $display("FAIL R5 ones: actual=%0d expected=128", ones);
        end
        total++;
        if (diff255 == 0) begin
            bad++;
            $display("FAIL R5 period 255: actual=0 expected=nonzero");
        end
        for (int i = 7; i < 512; i++)
            check("R10 trig lag", tg[i], nz[i-7]);

        // R7: inverted stream is the complement
        do_reset();
        {sel_invert, sel_source} = 2'b11;
        for (int i = 0; i < 256; i++) begin
            pulse(1);
            inz[i] = cal_out;
            check("R10 trig not inverted", trig_out, tg[i]);
        end
        for (int i = 0; i < 256; i++)
            check("R7 complement", inz[i], ~nz[i]);

        // R1: reset in mid-run restores the start
        pulse(10);
        do_reset();
        check("R1 mid-run cal", cal_out, 1'b0);
        {sel_invert, sel_source} = 2'b10;
        pulse(1);
        check("R1 R6 reseed", cal_out, 1'b1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule